// File: doc/BRIEF.md
# Privileged Control Register File

This block is the privileged control and status register store of a processor core. A single port carries a register index, a read strobe and a write strobe. A read returns data combinationally from the index. A write takes effect on the next clock edge. The store holds processor state, the trap base, the trap level, the window pointer, the hyper-state word, the MMU context and partition fields, a soft-interrupt word and eight scratchpad words.

The trap PC, trap next-PC, trap state, trap type and hyper trap state are each kept as a stack with one entry per trap level. The current trap level selects the entry. Some writes are filtered on the way in: the processor-state word is masked, the trap base is aligned, and the window pointer and trap level are clamped. The tick value is not a stored register. It is the sum of a free-running cycle counter and a stored offset. One read address returns a packed translation-context word built from several registers.

Accesses that cannot be served raise `err` in the same cycle as the access and return zero. These are unknown indices, reads of write-only addresses, writes to read-only addresses, and stack accesses at trap level zero.

Top module: `priv_csr_file`

## Requirements
- R1: After reset the strand status word (index 0x06) reads 0x50000. Every stack entry, every scratchpad word, the processor-state word (0x00), the soft-interrupt word (0x0D) and the trap level (0x02) read zero.
- R2: A write to index 0x00 stores only the bits selected by mask 0x13DE (bits 1–4, 6–9 and 12). All other bits read back as zero.
- R3: A write to the trap base (index 0x01) stores the value with bits 14:0 cleared.
- R4: Index 0x05 is read-only and reads NWIN | MAX_TL<<8 | MAX_GL<<16, which is 0x30608 with the default parameters. A write to it raises `err` and changes nothing.
- R5: Indices 0x10..0x14 select the trap PC, trap next-PC, trap state, trap type and hyper trap state stacks. An access uses the entry at (trap level − 1). At trap level 0 such an access raises `err`, reads zero and writes nothing. A trap-level write above MAX_TL stores MAX_TL.
- R6: A tick write (index 0x04) stores bits 62:0 minus the running cycle count as an offset, and keeps bit 63 separately. A tick read returns bit 63 from the kept bit and bits 62:2 from (count + offset), with bits 1:0 zero. The count is zero in the first cycle after reset and rises by one each cycle.
- R7: A window-pointer write (index 0x03) with a value above NWIN stores NWIN−1. Any other value is stored unchanged.
- R8: Index 0x0C reads a packed word. Bit 0 holds hyper-state bit 2 and bit 1 holds hyper-state bit 5. Bits 3:2 hold processor-state bits 3:2, and bits 5:4 hold LSU-control bits 3:2. Bits 15:8 hold the partition ID. Bits 18:16 hold the trap level. Bits 47:32 hold the primary context and bits 63:48 hold the secondary context. Writing 0x0C raises `err`. The source indices are hyper-state 0x07, LSU control 0x08, partition 0x09 (8 bits), primary 0x0A and secondary 0x0B (16 bits each).
- R9: Indices 0x18..0x1F are eight independent 64-bit scratchpad words.
- R10: Index 0x0D is the soft-interrupt word, 17 bits wide. A write to 0x0E ORs data into it and a write to 0x0F clears the bits that are set in the data. A read of 0x0E or 0x0F raises `err` and returns zero.
- R11: An access to an unimplemented index, for example 0x15 or 0x3F, returns zero and raises `err` in the same cycle.
- R12: A write becomes visible on the edge that ends its strobe cycle. In that strobe cycle, a read of the same index still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_idx | input | 6 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Combinational read data, zero when not reading or on error |
| err | output | 1 | Illegal or unimplemented access in this cycle |

## Verification
Two things meet on the same clock edge: a tick write, and the advance of the free-running counter that the offset is taken against. The bench writes the tick on a cycle whose count it knows from its own cycle counter. It then reads the tick several cycles later and expects the written value plus the elapsed cycles, with the low two bits cleared. The second collision is a read and a write of the same index in one strobe cycle. The read must return the old value, and the following cycle must return the new one.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;

    localparam int IDX_W   = 6;
    localparam int DATA_W  = 64;
    localparam int SPAD_N  = 8;
    localparam int N_STACK = 5;

    typedef enum logic [IDX_W-1:0] {
        IX_PSTATE  = 6'h00,
        IX_TBASE   = 6'h01,
        IX_TLVL    = 6'h02,
        IX_WINPTR  = 6'h03,
        IX_TICK    = 6'h04,
        IX_VERSION = 6'h05,
        IX_STRAND  = 6'h06,
        IX_HSTATE  = 6'h07,
        IX_LSUCTL  = 6'h08,
        IX_PARTN   = 6'h09,
        IX_PCTX    = 6'h0A,
        IX_SCTX    = 6'h0B,
        IX_XLATE   = 6'h0C,
        IX_SOFTI   = 6'h0D,
        IX_SOFTSET = 6'h0E,
        IX_SOFTCLR = 6'h0F
    } csr_idx_e;

    localparam logic [IDX_W-1:0] STACK_BASE = 6'h10;
    localparam logic [2:0]       SPAD_TAG   = 3'b011;

    localparam logic [DATA_W-1:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;
    localparam logic [DATA_W-1:0] TBASE_KEEP  = ~64'h0000_0000_0000_7FFF;
    localparam logic [DATA_W-1:0] STRAND_INIT = 64'h0000_0000_0005_0000;

    typedef struct packed {
        logic [DATA_W-1:0] hstate;
        logic [DATA_W-1:0] pstate;
        logic [DATA_W-1:0] lsuctl;
        logic [7:0]        partn;
        logic [2:0]        tlvl;
        logic [15:0]       pctx;
        logic [15:0]       sctx;
    } xlate_src_t;

    function automatic logic [DATA_W-1:0] pack_xlate(input xlate_src_t s);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = s.hstate[2];
        w[1]     = s.hstate[5];
        w[3:2]   = s.pstate[3:2];
        w[5:4]   = s.lsuctl[3:2];
        w[15:8]  = s.partn;
        w[18:16] = s.tlvl;
        w[47:32] = s.pctx;
        w[63:48] = s.sctx;
        return w;
    endfunction

endpackage

// File: rtl/priv_csr_tick.sv
module priv_csr_tick (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [63:0] wd,
    output logic [63:0] rd
);
    logic [63:0] count_q;
    logic [62:0] offset_q;
    logic        top_q;
    logic [62:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            offset_q <= '0;
            top_q    <= 1'b0;
        end else begin
            count_q <= count_q + 64'd1;
            if (we) begin
                offset_q <= wd[62:0] - count_q[62:0];
                top_q    <= wd[63];
            end
        end
    end

    always_comb begin
        sum = count_q[62:0] + offset_q;
        rd  = {top_q, sum[62:2], 2'b00};
    end
endmodule

// File: rtl/priv_csr_tstack.sv
module priv_csr_tstack #(
    parameter int DEPTH = 6,
    parameter int SW    = 3,
    parameter int W     = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd
);
    logic [W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (we && (int'(sel) < DEPTH)) begin
            slot_q[sel] <= wd;
        end
    end

    always_comb begin
        rd = '0;
        for (int i = 0; i < DEPTH; i++)
            if (int'(sel) == i) rd = slot_q[i];
    end
endmodule

// File: rtl/priv_csr_spad.sv
module priv_csr_spad #(
    parameter int N = 8,
    parameter int W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wsel,
    input  logic [W-1:0]         wd,
    input  logic [$clog2(N)-1:0] rsel,
    output logic [W-1:0]         rd
);
    logic [W-1:0] word_q [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                         word_q[g] <= '0;
            else if (we && int'(wsel) == g)  word_q[g] <= wd;
        end
    end

    assign rd = word_q[rsel];
endmodule

// File: rtl/priv_csr_file.sv
module priv_csr_file
    import priv_csr_pkg::*;
#(
    parameter int NWIN      = 8,
    parameter int MAX_TL    = 6,
    parameter int MAX_GL    = 3,
    parameter int SOFTINT_W = 17
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  csr_idx,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data,
    output logic        err
);
    localparam int TLW  = $clog2(MAX_TL + 1);
    localparam int CWPW = $clog2(NWIN + 1);
    localparam int SPW  = $clog2(SPAD_N);
    localparam logic [63:0] VERSION_WORD =
        64'(NWIN) | (64'(MAX_TL) << 8) | (64'(MAX_GL) << 16);

    logic [63:0]          pstate_q, tbase_q, hstate_q, lsuctl_q, strand_q;
    logic [TLW-1:0]       tlvl_q;
    logic [CWPW-1:0]      cwp_q;
    logic [7:0]           partn_q;
    logic [15:0]          pctx_q, sctx_q;
    logic [SOFTINT_W-1:0] softi_q;

    logic        is_stack, is_spad, tl_zero, known, ro, wo;
    logic        rd_bad, wr_bad, wr_ok;
    logic [63:0] rd_val, tick_rd, spad_rd, xlate_w;
    logic [2:0]  stack_no;
    logic [TLW-1:0] stack_sel;
    logic [63:0] stack_rd [N_STACK];
    xlate_src_t  xs;

    assign is_stack  = (csr_idx >= STACK_BASE) && (csr_idx < STACK_BASE + 6'(N_STACK));
    assign is_spad   = (csr_idx[5:3] == SPAD_TAG);
    assign stack_no  = 3'(csr_idx - STACK_BASE);
    assign tl_zero   = (tlvl_q == '0);
    assign stack_sel = tlvl_q - TLW'(1);

    always_comb begin
        xs.hstate = hstate_q;
        xs.pstate = pstate_q;
        xs.lsuctl = lsuctl_q;
        xs.partn  = partn_q;
        xs.tlvl   = 3'(tlvl_q);
        xs.pctx   = pctx_q;
        xs.sctx   = sctx_q;
        xlate_w   = pack_xlate(xs);
    end

    always_comb begin
        known  = 1'b1;
        ro     = 1'b0;
        wo     = 1'b0;
        rd_val = '0;
        if (is_stack) begin
            rd_val = stack_rd[stack_no];
        end else if (is_spad) begin
            rd_val = spad_rd;
        end else begin
            case (csr_idx)
                IX_PSTATE:  rd_val = pstate_q;
                IX_TBASE:   rd_val = tbase_q;
                IX_TLVL:    rd_val = 64'(tlvl_q);
                IX_WINPTR:  rd_val = 64'(cwp_q);
                IX_TICK:    rd_val = tick_rd;
                IX_VERSION: begin rd_val = VERSION_WORD; ro = 1'b1; end
                IX_STRAND:  rd_val = strand_q;
                IX_HSTATE:  rd_val = hstate_q;
                IX_LSUCTL:  rd_val = lsuctl_q;
                IX_PARTN:   rd_val = 64'(partn_q);
                IX_PCTX:    rd_val = 64'(pctx_q);
                IX_SCTX:    rd_val = 64'(sctx_q);
                IX_XLATE:   begin rd_val = xlate_w; ro = 1'b1; end
                IX_SOFTI:   rd_val = 64'(softi_q);
                IX_SOFTSET: wo = 1'b1;
                IX_SOFTCLR: wo = 1'b1;
                default:    known = 1'b0;
            endcase
        end
    end

    assign rd_bad  = !known || wo || (is_stack && tl_zero);
    assign wr_bad  = !known || ro || (is_stack && tl_zero);
    assign wr_ok   = wr_en && !wr_bad;
    assign err     = (rd_en && rd_bad) || (wr_en && wr_bad);
    assign rd_data = (rd_en && !rd_bad) ? rd_val : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pstate_q <= '0;
            tbase_q  <= '0;
            tlvl_q   <= '0;
            cwp_q    <= '0;
            hstate_q <= '0;
            lsuctl_q <= '0;
            strand_q <= STRAND_INIT;
            partn_q  <= '0;
            pctx_q   <= '0;
            sctx_q   <= '0;
            softi_q  <= '0;
        end else if (wr_ok && !is_stack && !is_spad) begin
            case (csr_idx)
                IX_PSTATE: pstate_q <= wr_data & PSTATE_KEEP;
                IX_TBASE:  tbase_q  <= wr_data & TBASE_KEEP;
                IX_TLVL:   tlvl_q   <= (wr_data > 64'(MAX_TL)) ? TLW'(MAX_TL) : wr_data[TLW-1:0];
                IX_WINPTR: cwp_q    <= (wr_data > 64'(NWIN)) ? CWPW'(NWIN - 1) : wr_data[CWPW-1:0];
                IX_STRAND: strand_q <= wr_data;
                IX_HSTATE: hstate_q <= wr_data;
                IX_LSUCTL: lsuctl_q <= wr_data;
                IX_PARTN:  partn_q  <= wr_data[7:0];
                IX_PCTX:   pctx_q   <= wr_data[15:0];
                IX_SCTX:   sctx_q   <= wr_data[15:0];
                IX_SOFTI:   softi_q <= wr_data[SOFTINT_W-1:0];
                IX_SOFTSET: softi_q <= softi_q | wr_data[SOFTINT_W-1:0];
                IX_SOFTCLR: softi_q <= softi_q & ~wr_data[SOFTINT_W-1:0];
                default: ;
            endcase
        end
    end

    priv_csr_tick u_tick (
        .clk (clk),
        .rst (rst),
        .we  (wr_ok && csr_idx == IX_TICK),
        .wd  (wr_data),
        .rd  (tick_rd)
    );

    for (genvar s = 0; s < N_STACK; s++) begin : g_stack
        priv_csr_tstack #(.DEPTH(MAX_TL), .SW(TLW), .W(64)) u_stk (
            .clk (clk),
            .rst (rst),
            .we  (wr_ok && is_stack && int'(stack_no) == s),
            .sel (stack_sel),
            .wd  (wr_data),
            .rd  (stack_rd[s])
        );
    end

    priv_csr_spad #(.N(SPAD_N), .W(64)) u_spad (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_ok && is_spad),
        .wsel (csr_idx[SPW-1:0]),
        .wd   (wr_data),
        .rsel (csr_idx[SPW-1:0]),
        .rd   (spad_rd)
    );
endmodule

// File: rtl/priv_csr_file_chk.sv
module priv_csr_file_chk #(
    parameter int NWIN = 8,
    parameter int CWPW = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [5:0]      csr_idx,
    input logic            rd_en,
    input logic            wr_en,
    input logic [63:0]     wr_data,
    input logic [63:0]     rd_data,
    input logic            err,
    input logic [CWPW-1:0] cwp_q
);
    // R2
    pstate_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && csr_idx == 6'h00) |-> ((rd_data & ~64'h13DE) == 64'd0));

    // R3
    tbase_align_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && csr_idx == 6'h01) |-> (rd_data[14:0] == 15'd0));

    // R6
    tick_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && csr_idx == 6'h04) |-> (rd_data[1:0] == 2'b00));

    // R7
    winptr_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && csr_idx == 6'h03 && wr_data > 64'(NWIN)) |=> (int'(cwp_q) == NWIN - 1));

    // R10
    softint_wo_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (csr_idx == 6'h0E || csr_idx == 6'h0F)) |-> (err && rd_data == 64'd0));

    // R11
    unimpl_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (csr_idx == 6'h15 || csr_idx == 6'h3F)) |-> (err && rd_data == 64'd0));
endmodule

bind priv_csr_file priv_csr_file_chk #(.NWIN(NWIN), .CWPW(CWPW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .csr_idx (csr_idx),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .err     (err),
    .cwp_q   (cwp_q)
);

// File: tb/priv_csr_file_tb.sv
`timescale 1ns/1ps
module priv_csr_file_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  csr_idx = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [63:0] tbc;

    always #5 clk = ~clk;

    always @(posedge clk)
        if (rst) tbc <= '0; else tbc <= tbc + 64'd1;

    priv_csr_file u_dut (
        .clk(clk), .rst(rst), .csr_idx(csr_idx), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .err(err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] ix, input logic [63:0] d,
                      output logic e, output logic [63:0] cnt);
        @(negedge clk);
        csr_idx = ix; wr_data = d; wr_en = 1'b1; cnt = tbc;
        #1 e = err;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] ix, output logic [63:0] d, output logic e);
        @(negedge clk);
        csr_idx = ix; rd_en = 1'b1;
        #1 d = rd_data; e = err;
        rd_en = 1'b0;
    endtask

    function automatic logic [63:0] exp_tick(input logic [63:0] v, input logic [63:0] wcnt,
                                             input logic [63:0] now);
        logic [62:0] off, s;
        off = v[62:0] - wcnt[62:0];
        s   = now[62:0] + off;
        return {v[63], s[62:2], 2'b00};
    endfunction

    function automatic logic [63:0] exp_xlate(input logic [63:0] hs, ps, lsu,
                                              input logic [7:0] pt, input logic [2:0] tl,
                                              input logic [15:0] pc, sc);
        return {sc, pc, 13'd0, tl, pt, 2'b00, lsu[3:2], ps[3:2], hs[5], hs[2]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, c, v, spm [8];
        logic e;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset values
        rd(6'h06, d, e); check("R1 strand", d, 64'h50000);
        rd(6'h1B, d, e); check("R1 scratch", d, 64'd0);
        rd(6'h00, d, e); check("R1 pstate", d, 64'd0);
        rd(6'h0D, d, e); check("R1 softint", d, 64'd0);
        rd(6'h02, d, e); check("R1 tlvl", d, 64'd0);
        wr(6'h02, 64'd2, e, c);
        rd(6'h10, d, e); check("R1 stack", d, 64'd0);

        // R2 mask
        wr(6'h00, '1, e, c);
        rd(6'h00, d, e); check("R2 all ones", d, 64'h13DE);
        wr(6'h00, 64'h0000_0000_0000_0A55, e, c);
        rd(6'h00, d, e); check("R2 pattern", d, 64'h0A55 & 64'h13DE);

        // R3 trap base alignment
        wr(6'h01, 64'h1234_5678_9ABC_DEF1, e, c);
        rd(6'h01, d, e); check("R3 tbase", d, 64'h1234_5678_9ABC_8000);

        // R4 version word, read-only
        rd(6'h05, d, e); check("R4 version", d, 64'h30608);
        wr(6'h05, 64'hFFFF, e, c); check("R4 write err", 64'(e), 64'd1);
        rd(6'h05, d, e); check("R4 unchanged", d, 64'h30608);

        // R5 stacks by level
        wr(6'h02, 64'd3, e, c); wr(6'h10, 64'hAAAA_0003, e, c);
        wr(6'h13, 64'h33, e, c);
        wr(6'h02, 64'd1, e, c); wr(6'h10, 64'hBBBB_0001, e, c);
        rd(6'h10, d, e); check("R5 level1", d, 64'hBBBB_0001);
        wr(6'h02, 64'd3, e, c);
        rd(6'h10, d, e); check("R5 level3", d, 64'hAAAA_0003);
        rd(6'h13, d, e); check("R5 tt level3", d, 64'h33);
        wr(6'h02, 64'd2, e, c);
        rd(6'h10, d, e); check("R5 level2", d, 64'd0);
        wr(6'h02, 64'd0, e, c);
        rd(6'h10, d, e); check("R5 tl0 err", 64'(e), 64'd1); check("R5 tl0 data", d, 64'd0);
        wr(6'h14, 64'h77, e, c); check("R5 tl0 wr err", 64'(e), 64'd1);
        wr(6'h02, 64'd9, e, c);
        rd(6'h02, d, e); check("R5 tl clamp", d, 64'd6);

        // R6 tick against running count
        v = 64'h8000_0000_0000_1000;
        wr(6'h04, v, e, c);
        repeat (5) @(negedge clk);
        rd(6'h04, d, e); check("R6 tick hi", d, exp_tick(v, c, tbc));
        v = 64'h0123_4567_89AB_CDEF;
        wr(6'h04, v, e, c);
        repeat (2) @(negedge clk);
        rd(6'h04, d, e); check("R6 tick lo", d, exp_tick(v, c, tbc));

        // R7 window pointer clamp
        wr(6'h03, 64'd9, e, c);  rd(6'h03, d, e); check("R7 above", d, 64'd7);
        wr(6'h03, 64'd8, e, c);  rd(6'h03, d, e); check("R7 equal", d, 64'd8);
        wr(6'h03, 64'd3, e, c);  rd(6'h03, d, e); check("R7 below", d, 64'd3);

        // R8 packed translation word
        wr(6'h07, 64'h24, e, c); wr(6'h00, 64'h0C, e, c);
        wr(6'h08, 64'h08, e, c); wr(6'h09, 64'h5A, e, c);
        wr(6'h02, 64'd5, e, c);  wr(6'h0A, 64'hBEEF, e, c);
        wr(6'h0B, 64'hCAFE, e, c);
        rd(6'h0C, d, e);
        check("R8 pack", d, exp_xlate(64'h24, 64'h0C, 64'h08, 8'h5A, 3'd5, 16'hBEEF, 16'hCAFE));
        wr(6'h0C, 64'd1, e, c); check("R8 ro err", 64'(e), 64'd1);

        // R9 scratchpad, random
        for (int i = 0; i < 8; i++) spm[i] = '0;
        for (int i = 0; i < 40; i++) begin
            int k;
            k = int'($urandom_range(7));
            v = {$urandom, $urandom};
            wr(6'h18 + 6'(k), v, e, c); spm[k] = v;
            k = int'($urandom_range(7));
            rd(6'h18 + 6'(k), d, e); check("R9 scratch", d, spm[k]);
        end

        // R10 soft interrupt
        wr(6'h0D, 64'hF_00F0, e, c);
        rd(6'h0D, d, e); check("R10 direct", d, 64'hF_00F0 & 64'h1_FFFF);
        wr(6'h0E, 64'h101, e, c);
        rd(6'h0D, d, e); check("R10 set", d, 64'h1_01F1);
        wr(6'h0F, 64'h1_0030, e, c);
        rd(6'h0D, d, e); check("R10 clr", d, 64'h01C1);
        rd(6'h0E, d, e); check("R10 rd set err", 64'(e), 64'd1); check("R10 rd set data", d, 64'd0);

        // R11 unimplemented
        rd(6'h15, d, e); check("R11 err", 64'(e), 64'd1); check("R11 data", d, 64'd0);
        wr(6'h3F, 64'd1, e, c); check("R11 wr err", 64'(e), 64'd1);

        // R12 same-cycle read and write
        @(negedge clk);
        csr_idx = 6'h1C; wr_data = 64'hDEAD_BEEF_0000_1111; wr_en = 1'b1; rd_en = 1'b1;
        #1 check("R12 old value", rd_data, spm[4]);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R12 new value", rd_data, 64'hDEAD_BEEF_0000_1111);
        rd_en = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule